// File: doc/BRIEF.md
# Stop-State Wake-Up Sequencer

This block brings a small microcontroller core back out of its clock-stopped low-power state. The core asks to stop with a one-cycle request. While stopped, the block watches two kinds of wake source: a watchdog time-out pulse, and level changes on general-purpose input pins that software has enabled for wake-up. Pin inputs are synchronised, then filtered so that short glitches cannot wake the part. A pin counts as changed only when its filtered level differs from the level it had when the stop began.

When a wake source fires, the block holds the core in reset for a fixed number of internal-oscillator cycles, which is 66 by default. During the same cycle it records the cause in a small status register and returns the oscillator-control register to its default value. No other state is touched, because this is a partial recovery and not a power-on reset. When the hold ends, the block gives a one-cycle vector-fetch strobe that carries the address of the reset vector. The high byte of the vector is at that address and the low byte is at the next one. If the watchdog is set to exception mode, an exception request follows one cycle later.

Top module: `stopwake_ctrl`

## Requirements
- R1: A one-cycle `stop_req_i` in the running state makes `stopped_o` high from the next cycle. At most one of `stopped_o`, `core_rst_o`, `vec_fetch_o` and `wdt_exc_o` is high at any time. A stop request in any other state is ignored.
- R2: A wake event in the stopped state raises `core_rst_o` from the next cycle for exactly HOLD_CYC consecutive cycles (66 by default).
- R3: In the cycle right after the hold, `vec_fetch_o` is high for one cycle. `vec_addr_o` always reads VEC_ADDR (0x0002), the address of the vector's high byte; the low byte is at VEC_ADDR+1.
- R4: Every recovery sets `stat_stop_o` to 1 in the first hold cycle.
- R5: A watchdog time-out while stopped starts recovery and sets both `stat_wdt_o` and `stat_stop_o`. When a pin event and a time-out arrive in the same cycle, `stat_wdt_o` is still set.
- R6: If `wdt_exc_mode_i` is 1 at the time-out, `wdt_exc_o` is high for one cycle right after the vector-fetch cycle. If it is 0, no exception pulse occurs.
- R7: A pin whose `pin_wake_en_i` bit is 1 wakes the block on a rising or a falling change. A pin whose bit is 0 has no effect.
- R8: Each pin passes through a two-flop synchroniser and a filter. A new level held for fewer than FILT_N sampling clocks is rejected. A new level held for FILT_N or more clocks is accepted.
- R9: The reference level of each pin is its filtered level at the moment the stop begins. A level reached before the stop does not cause a wake.
- R10: Watchdog and pin events during the hold, vector or exception cycles are ignored. They neither extend the sequence nor change the status bits.
- R11: Recovery reloads `osc_ctl_o` with OSC_RST and changes nothing else. Software writes `osc_ctl_o` with `osc_wr_i`. `stat_w1c_i` bit 0 clears the STOP bit and bit 1 clears the WDT bit. A set in the same cycle wins over a clear.
- R12: The synchronous power-on reset `rst` clears both status bits, loads OSC_RST and puts the block in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| stop_req_i | input | 1 | One-cycle stop request from the core |
| wdt_timeout_i | input | 1 | Watchdog time-out pulse |
| wdt_exc_mode_i | input | 1 | 1 = watchdog acts as exception, 0 = as reset |
| pin_i | input | NPINS | Asynchronous general-purpose pin levels |
| pin_wake_en_i | input | NPINS | Per-pin wake enable |
| stat_w1c_i | input | 2 | Write-one-to-clear: bit 0 STOP, bit 1 WDT |
| osc_wr_i | input | 1 | Oscillator-control write strobe |
| osc_wdata_i | input | OSC_W | Oscillator-control write data |
| core_rst_o | output | 1 | Core reset hold |
| vec_fetch_o | output | 1 | One-cycle reset-vector fetch strobe |
| vec_addr_o | output | AW | Address of reset vector high byte |
| wdt_exc_o | output | 1 | One-cycle watchdog exception request |
| stopped_o | output | 1 | Block is in the stopped state |
| stat_stop_o | output | 1 | STOP status bit |
| stat_wdt_o | output | 1 | WDT status bit |
| osc_ctl_o | output | OSC_W | Oscillator-control register |

## Verification
The bench builds the block with NPINS=4 and FILT_N=3, and keeps the default hold of 66 cycles. The short filter lets the bench try pulses of two and three clocks and so reach both sides of the glitch boundary. Four pins are enough to have enabled and disabled pins side by side, and a pin that changes before the stop begins. With the real 66-cycle hold, the bench can check that events arriving during the hold are ignored, and that the release lines up with the vector and exception strobes.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

    typedef enum logic [2:0] {
        SW_RUN  = 3'd0,
        SW_STOP = 3'd1,
        SW_HOLD = 3'd2,
        SW_VEC  = 3'd3,
        SW_EXC  = 3'd4
    } sw_state_e;

    typedef struct packed {
        logic wdt;
        logic stop;
    } sw_stat_t;

    typedef struct packed {
        logic fire;
        logic by_wdt;
        logic want_exc;
    } sw_wake_t;

    function automatic logic any_change(input logic [63:0] cur, input logic [63:0] ref_lvl,
                                        input logic [63:0] en);
        return |((cur ^ ref_lvl) & en);
    endfunction

endpackage

// File: rtl/swk_pin_filter.sv
module swk_pin_filter #(
    parameter int FILT_N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o
);
    localparam int CW = $clog2(FILT_N + 1);

    logic          sync_a, sync_b;
    logic          lvl_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            lvl_q  <= 1'b0;
            run_q  <= '0;
        end else begin
            sync_a <= pin_i;
            sync_b <= sync_a;
            if (sync_b == lvl_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_N - 1)) begin
                lvl_q <= sync_b;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level_o = lvl_q;

    // R8: the filtered level only moves to a value the synchroniser was showing
    p_flt_follows_sync_r8: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> ($past(sync_b) == lvl_q));

endmodule

// File: rtl/swk_hold_timer.sv
module swk_hold_timer #(
    parameter int HOLD_CYC = 66
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic en_i,
    output logic last_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            cnt_q <= '0;
        end else if (en_i && !last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == HW'(HOLD_CYC - 1));

endmodule

// File: rtl/swk_status.sv
module swk_status
    import stopwake_pkg::*;
#(
    parameter int          OSC_W   = 8,
    parameter logic [OSC_W-1:0] OSC_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  sw_wake_t         wake_i,
    input  logic [1:0]       w1c_i,
    input  logic             osc_wr_i,
    input  logic [OSC_W-1:0] osc_wdata_i,
    output sw_stat_t         stat_o,
    output logic [OSC_W-1:0] osc_o
);
    sw_stat_t         stat_q;
    logic [OSC_W-1:0] osc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            osc_q  <= OSC_RST;
        end else begin
            if (wake_i.fire) stat_q.stop <= 1'b1;
            else if (w1c_i[0]) stat_q.stop <= 1'b0;
            if (wake_i.fire && wake_i.by_wdt) stat_q.wdt <= 1'b1;
            else if (w1c_i[1]) stat_q.wdt <= 1'b0;
            if (wake_i.fire) osc_q <= OSC_RST;
            else if (osc_wr_i) osc_q <= osc_wdata_i;
        end
    end

    assign stat_o = stat_q;
    assign osc_o  = osc_q;

endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
    import stopwake_pkg::*;
#(
    parameter int               NPINS    = 8,
    parameter int               FILT_N   = 4,
    parameter int               HOLD_CYC = 66,
    parameter int               AW       = 16,
    parameter logic [AW-1:0]    VEC_ADDR = 16'h0002,
    parameter int               OSC_W    = 8,
    parameter logic [OSC_W-1:0] OSC_RST  = 8'hA0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_req_i,
    input  logic             wdt_timeout_i,
    input  logic             wdt_exc_mode_i,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] pin_wake_en_i,
    input  logic [1:0]       stat_w1c_i,
    input  logic             osc_wr_i,
    input  logic [OSC_W-1:0] osc_wdata_i,
    output logic             core_rst_o,
    output logic             vec_fetch_o,
    output logic [AW-1:0]    vec_addr_o,
    output logic             wdt_exc_o,
    output logic             stopped_o,
    output logic             stat_stop_o,
    output logic             stat_wdt_o,
    output logic [OSC_W-1:0] osc_ctl_o
);
    sw_state_e        st_q;
    logic [NPINS-1:0] flt;
    logic [NPINS-1:0] ref_q;
    logic             exc_pend_q;
    logic             hold_last;
    sw_wake_t         wake;
    sw_stat_t         stat;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        swk_pin_filter #(.FILT_N(FILT_N)) u_flt (
            .clk     (clk),
            .rst     (rst),
            .pin_i   (pin_i[p]),
            .level_o (flt[p])
        );
    end

    always_comb begin
        wake.by_wdt   = wdt_timeout_i;
        wake.fire     = (st_q == SW_STOP) &&
                        (wdt_timeout_i || any_change(64'(flt), 64'(ref_q), 64'(pin_wake_en_i)));
        wake.want_exc = wdt_timeout_i && wdt_exc_mode_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= SW_RUN;
            ref_q      <= '0;
            exc_pend_q <= 1'b0;
        end else begin
            unique case (st_q)
                SW_RUN: if (stop_req_i) begin
                    st_q  <= SW_STOP;
                    ref_q <= flt;
                end
                SW_STOP: if (wake.fire) begin
                    st_q       <= SW_HOLD;
                    exc_pend_q <= wake.want_exc;
                end
                SW_HOLD: if (hold_last) st_q <= SW_VEC;
                SW_VEC:  st_q <= exc_pend_q ? SW_EXC : SW_RUN;
                default: st_q <= SW_RUN;
            endcase
        end
    end

    swk_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (wake.fire),
        .en_i   (st_q == SW_HOLD),
        .last_o (hold_last)
    );

    swk_status #(.OSC_W(OSC_W), .OSC_RST(OSC_RST)) u_stat (
        .clk         (clk),
        .rst         (rst),
        .wake_i      (wake),
        .w1c_i       (stat_w1c_i),
        .osc_wr_i    (osc_wr_i),
        .osc_wdata_i (osc_wdata_i),
        .stat_o      (stat),
        .osc_o       (osc_ctl_o)
    );

    assign core_rst_o  = (st_q == SW_HOLD);
    assign vec_fetch_o = (st_q == SW_VEC);
    assign wdt_exc_o   = (st_q == SW_EXC);
    assign stopped_o   = (st_q == SW_STOP);
    assign vec_addr_o  = VEC_ADDR;
    assign stat_stop_o = stat.stop;
    assign stat_wdt_o  = stat.wdt;

    // R1: sequence phases are mutually exclusive
    p_phase_excl_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({core_rst_o, vec_fetch_o, wdt_exc_o, stopped_o}));
    // R3: reset release is followed by the vector strobe in that very cycle
    p_release_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst_o) |-> vec_fetch_o);
    // R2: the hold only starts out of the stopped state
    p_hold_from_stop_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst_o) |-> $past(stopped_o));
    // R4: entering the hold has recorded the STOP cause
    p_stop_bit_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst_o) |-> stat_stop_o);
    // R5: time-out while stopped records the WDT cause
    p_wdt_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (stopped_o && wdt_timeout_i) |=> (stat_wdt_o && core_rst_o));
    // R6: exception request only directly after the vector strobe
    p_exc_after_fetch_r6: assert property (@(posedge clk) disable iff (rst)
        wdt_exc_o |-> $past(vec_fetch_o));

endmodule

// File: tb/stopwake_ctrl_tb_top.sv
module stopwake_ctrl_tb_top;
    localparam int NP = 4;
    localparam int FN = 3;
    localparam int HC = 66;
    localparam logic [7:0] ORST = 8'hA0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 0, wdt_to = 0, wdt_mode = 0, osc_wr = 0;
    logic [NP-1:0] pins = '0, pen = '0;
    logic [1:0] w1c = '0;
    logic [7:0] osc_wd = '0;
    logic core_rst, vfetch, wexc, stopped, sstop, swdt;
    logic [15:0] vaddr;
    logic [7:0] oscv;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    stopwake_ctrl #(.NPINS(NP), .FILT_N(FN), .HOLD_CYC(HC), .OSC_RST(ORST)) dut_i (
        .clk(clk), .rst(rst), .stop_req_i(stop_req), .wdt_timeout_i(wdt_to),
        .wdt_exc_mode_i(wdt_mode), .pin_i(pins), .pin_wake_en_i(pen),
        .stat_w1c_i(w1c), .osc_wr_i(osc_wr), .osc_wdata_i(osc_wd),
        .core_rst_o(core_rst), .vec_fetch_o(vfetch), .vec_addr_o(vaddr),
        .wdt_exc_o(wexc), .stopped_o(stopped), .stat_stop_o(sstop),
        .stat_wdt_o(swdt), .osc_ctl_o(oscv)
    );

    // reference model state: 0 run, 1 stopped, 2 hold, 3 vector, 4 exception
    int m_st = 0, m_hc = 0, m_pend = 0, m_sstop = 0, m_swdt = 0, m_osc = ORST;
    int m_h1[NP], m_h2[NP], m_f[NP], m_run[NP], m_ref[NP];

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_hc = 0; m_pend = 0; m_sstop = 0; m_swdt = 0; m_osc = ORST;
            for (int p = 0; p < NP; p++) begin
                m_h1[p] = 0; m_h2[p] = 0; m_f[p] = 0; m_run[p] = 0; m_ref[p] = 0;
            end
        end else begin
            int wk;
            wk = 0;
            for (int p = 0; p < NP; p++)
                if (pen[p] && m_f[p] != m_ref[p]) wk = 1;
            if (w1c[0]) m_sstop = 0;
            if (w1c[1]) m_swdt = 0;
            if (osc_wr) m_osc = osc_wd;
            case (m_st)
                0: if (stop_req) begin
                       m_st = 1;
                       for (int p = 0; p < NP; p++) m_ref[p] = m_f[p];
                   end
                1: if (wdt_to || wk) begin
                       m_st = 2; m_hc = 0; m_sstop = 1; m_osc = ORST;
                       if (wdt_to) m_swdt = 1;
                       m_pend = (wdt_to && wdt_mode) ? 1 : 0;
                   end
                2: if (m_hc == HC - 1) m_st = 3; else m_hc++;
                3: m_st = m_pend ? 4 : 0;
                default: m_st = 0;
            endcase
            for (int p = 0; p < NP; p++) begin
                if (m_h2[p] != m_f[p]) begin
                    if (m_run[p] == FN - 1) begin m_f[p] = m_h2[p]; m_run[p] = 0; end
                    else m_run[p]++;
                end else m_run[p] = 0;
                m_h2[p] = m_h1[p];
                m_h1[p] = int'(pins[p]);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(stopped  == (m_st == 1), "R1 stopped_o",  stopped,  m_st == 1);
            chk(core_rst == (m_st == 2), "R2 core_rst_o", core_rst, m_st == 2);
            chk(vfetch   == (m_st == 3), "R3 vec_fetch_o", vfetch,  m_st == 3);
            chk(vaddr    == 16'h0002,    "R3 vec_addr_o", vaddr,    2);
            chk(wexc     == (m_st == 4), "R6 wdt_exc_o",  wexc,     m_st == 4);
            chk(sstop    == m_sstop,     "R4 stat_stop_o", sstop,   m_sstop);
            chk(swdt     == m_swdt,      "R5 stat_wdt_o", swdt,     m_swdt);
            chk(oscv     == m_osc,       "R11 osc_ctl_o", oscv,     m_osc);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_stop();
        stop_req = 1; cyc(1); stop_req = 0;
    endtask

    task automatic pulse_wdt(input logic mode);
        wdt_mode = mode; wdt_to = 1; cyc(1); wdt_to = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        // R12: power-on state
        chk(!stopped && !sstop && !swdt && oscv == ORST, "R12 reset state", {stopped, sstop, swdt}, 0);

        // R11 write, then R7 rising edge on enabled pin 0
        osc_wd = 8'h5A; osc_wr = 1; cyc(1); osc_wr = 0;
        pen = 4'b0001;
        pulse_stop(); cyc(3);
        pins[0] = 1; cyc(FN + 4);
        chk(core_rst, "R7 rising edge wakes", core_rst, 1);
        cyc(HC + 4);
        chk(oscv == ORST, "R11 osc reloaded", oscv, ORST);
        chk(sstop && !swdt, "R4 stop only", {sstop, swdt}, 2);

        // R11 W1C; R1 stop during hold ignored; R10 events during hold
        w1c = 2'b01; cyc(1); w1c = 0;
        pulse_stop(); cyc(2);
        pulse_wdt(1); cyc(5);
        w1c = 2'b10; cyc(1); w1c = 0;
        stop_req = 1; pulse_wdt(0); stop_req = 0;
        pins[1] = 1; pen = 4'b0011; cyc(10);
        chk(core_rst && !swdt, "R10 hold ignores events", swdt, 0);
        cyc(HC);
        chk(!stopped && !core_rst, "R1 stop in hold ignored", stopped, 0);
        pins[1] = 0; cyc(10);

        // R8 glitch shorter than FN rejected, FN accepted
        pen = 4'b0010;
        pulse_stop(); cyc(3);
        pins[1] = 1; cyc(FN - 1); pins[1] = 0; cyc(15);
        chk(stopped, "R8 short pulse rejected", stopped, 1);
        pins[1] = 1; cyc(FN); pins[1] = 0; cyc(6);
        chk(core_rst, "R8 full-width pulse accepted", core_rst, 1);
        cyc(HC + 5);

        // R7 disabled pin ignored, falling edge on pin 0 wakes
        pen = 4'b0001;
        pulse_stop(); cyc(3);
        pins[2] = 1; cyc(15);
        chk(stopped, "R7 disabled pin ignored", stopped, 1);
        pins[0] = 0; cyc(FN + 4);
        chk(core_rst, "R7 falling edge wakes", core_rst, 1);
        cyc(HC + 5);

        // R9 level reached before stop does not wake
        pen = 4'b1000; pins[3] = 1; cyc(10);
        pulse_stop(); cyc(20);
        chk(stopped, "R9 reference at entry", stopped, 1);

        // R5 simultaneous pin and watchdog, reset mode (R6 no exception)
        w1c = 2'b11; cyc(1); w1c = 0;
        pins[3] = 0; cyc(FN + 2);
        pulse_wdt(0); cyc(HC + 5);
        chk(swdt && sstop, "R5 both bits", {swdt, sstop}, 3);
        pulse_stop(); cyc(3);
        rst = 1; cyc(2); rst = 0; cyc(1);
        chk(!stopped && !sstop && !swdt, "R12 reset from stop", {stopped, sstop, swdt}, 0);
        cyc(5);
        finish_run();
    end

endmodule